// File: doc/BRIEF.md
# Circulating Character Screen Memory

This block holds a text screen in a ring of shift registers instead of an addressable RAM. Every character strobe moves the whole ring by one position. The character leaving the last stage goes back into the first stage and is copied to a display stream, so a read never destroys data. A position counter follows which stored cell is at the tap. Each character on the stream carries the row and column at which it should be painted.

Software never addresses the storage directly. A write request names a target position and a character. The request waits until that position reaches the tap, and then the new character replaces the one being recirculated.

A one-line scroll copies nothing. The display stream goes silent for one row's worth of strobes while the ring keeps turning. A row-offset register then moves forward by one row, so the row that was second is painted at the top. The default geometry is 25 rows of 72 columns with 6-bit characters. The ring is split into chained 200-cell segments, and every bit of a character moves on its own parallel track.

Top module: `circ_screen_mem`

## Requirements
- R1: After reset, outValid, wrPending and scrollBusy are low, the position and the row offset are 0, and every stored character is 0. The first ROWS*COLS strobes therefore show zero characters.
- R2: A cycle with chrTick high produces exactly one output: outValid is high in the next cycle, unless a scroll is in progress. outValid is low in every cycle that does not follow a strobe.
- R3: Characters recirculate unchanged. When no write lands, the character shown for position p is the same character that was shown for p one full turn (ROWS*COLS strobes) earlier.
- R4: The tap position p starts at 0 and advances by 1 modulo ROWS*COLS on each strobe. For the character shown, outRow = q / COLS and outCol = q % COLS, where q = (p - rowOffset*COLS) mod ROWS*COLS.
- R5: A request (wrEn high, wrPos < ROWS*COLS, no write pending) is captured at the clock edge, and wrPending goes high. On the next strobe at which the tap position equals wrPos, the character shown and stored is wrData. wrPending is low in the cycle after that strobe.
- R6: wrEn is ignored while a write is pending or when wrPos >= ROWS*COLS. Neither the pending request nor the stored data changes.
- R7: scrollReq while no scroll is in progress raises scrollBusy at the next edge. The next COLS strobes produce no output. At the last of those strobes, scrollBusy falls and the row offset advances by 1 modulo ROWS.
- R8: scrollReq while a scroll is in progress is ignored. The scroll still ends after exactly COLS strobes from its start.
- R9: During a scroll the ring and the position counter keep advancing, and pending writes still land. After the scroll, the first character shown has its row and column given by R4 with the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chrTick | input | 1 | Character strobe; advances the ring by one position |
| wrEn | input | 1 | Write request |
| wrPos | input | $clog2(ROWS*COLS) | Target position of the write |
| wrData | input | CHAR_W | Character to write |
| scrollReq | input | 1 | Request a one-row scroll |
| outValid | output | 1 | Display stream character valid |
| outChar | output | CHAR_W | Character at the tap |
| outRow | output | $clog2(ROWS) | Screen row of outChar |
| outCol | output | $clog2(COLS) | Screen column of outChar |
| wrPending | output | 1 | A captured write has not landed yet |
| scrollBusy | output | 1 | Scroll skip in progress |

## Verification
A misplaced position counter or row offset shows up on outRow and outCol at the very next valid character. A corrupted or lost ring cell shows up only when that cell next passes the tap, at most one full turn of ROWS*COLS strobes later. Because of that, the bench runs several full turns both after writes and after scrolls. A write landing at the wrong position shows on the stream at once, as the wrong character at the expected position. Its side effect, a missing character at the intended position, appears later. A miscounted skip window shows within COLS strobes, as a valid pulse that should not be there or one that is missing.

// File: rtl/circ_screen_pkg.sv
package circ_screen_pkg;
  // Strobes from control to the datapath
  typedef struct packed {
    logic advance;  // rotate the ring by one cell
    logic capture;  // latch wrData as the pending character
    logic insert;   // pending character replaces the tap this rotation
  } ringStrb_t;
endpackage

// File: rtl/circ_screen_store.sv
module circ_screen_store
  import circ_screen_pkg::*;
#(
  parameter int ROWS    = 25,
  parameter int COLS    = 72,
  parameter int CHAR_W  = 6,
  parameter int SEG_LEN = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrb_t         strb,
  input  logic [CHAR_W-1:0] wrData,
  output logic [CHAR_W-1:0] outChar
);
  localparam int N    = ROWS * COLS;
  localparam int NSEG = (N + SEG_LEN - 1) / SEG_LEN;

  logic [CHAR_W-1:0] segIn   [NSEG];
  logic [CHAR_W-1:0] segTail [NSEG];
  logic [CHAR_W-1:0] pendData;
  logic [CHAR_W-1:0] tap;
  logic [CHAR_W-1:0] newVal;

  assign tap    = segTail[NSEG-1];
  assign newVal = strb.insert ? pendData : tap;

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    localparam int LEN = (g == NSEG - 1) ? (N - (NSEG - 1) * SEG_LEN) : SEG_LEN;
    logic [CHAR_W-1:0] cells [LEN];

    if (g == 0) begin : gHead
      assign segIn[g] = newVal;
    end else begin : gLink
      assign segIn[g] = segTail[g-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < LEN; i++) cells[i] <= '0;
      end else if (strb.advance) begin
        cells[0] <= segIn[g];
        for (int i = 1; i < LEN; i++) cells[i] <= cells[i-1];
      end
    end
    assign segTail[g] = cells[LEN-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendData <= '0;
      outChar  <= '0;
    end else begin
      if (strb.capture) pendData <= wrData;
      if (strb.advance) outChar  <= newVal;
    end
  end

  // Without an insert, the shown character is what sat at the tap
  assert_recirc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.insert) |=> outChar == $past(tap));
  // An insert shows the latched write data
  assert_insert_shown_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.insert) |=> outChar == $past(pendData));
endmodule

// File: rtl/circ_screen_ctrl.sv
module circ_screen_ctrl
  import circ_screen_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 72,
  localparam int N     = ROWS * COLS,
  localparam int POS_W = $clog2(N),
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CNT_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chrTick,
  input  logic             wrEn,
  input  logic [POS_W-1:0] wrPos,
  input  logic             scrollReq,
  output ringStrb_t        strb,
  output logic             outValid,
  output logic [ROW_W-1:0] outRow,
  output logic [COL_W-1:0] outCol,
  output logic             wrPending,
  output logic             scrollBusy
);
  logic [POS_W-1:0] pos, pendPos, offWords, rel;
  logic [ROW_W-1:0] rowOff;
  logic [CNT_W-1:0] skipCnt;
  logic             lastSkip;

  assign strb.advance = chrTick;
  assign strb.capture = wrEn && !wrPending && (int'(wrPos) < N);
  assign strb.insert  = chrTick && wrPending && (pendPos == pos);
  assign lastSkip     = chrTick && scrollBusy && (skipCnt == CNT_W'(1));

  always_comb begin
    offWords = POS_W'(int'(rowOff) * COLS);
    if (pos >= offWords) rel = pos - offWords;
    else                 rel = POS_W'(int'(pos) + N - int'(offWords));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos        <= '0;
      pendPos    <= '0;
      wrPending  <= 1'b0;
      rowOff     <= '0;
      scrollBusy <= 1'b0;
      skipCnt    <= '0;
      outValid   <= 1'b0;
      outRow     <= '0;
      outCol     <= '0;
    end else begin
      outValid <= chrTick && !scrollBusy;
      if (chrTick) begin
        outRow <= ROW_W'(int'(rel) / COLS);
        outCol <= COL_W'(int'(rel) % COLS);
        pos    <= (int'(pos) == N - 1) ? '0 : pos + POS_W'(1);
      end
      // write request bookkeeping
      if (strb.capture) begin
        wrPending <= 1'b1;
        pendPos   <= wrPos;
      end else if (strb.insert) begin
        wrPending <= 1'b0;
      end
      // scroll skip window
      if (scrollBusy) begin
        if (lastSkip) begin
          scrollBusy <= 1'b0;
          rowOff     <= (int'(rowOff) == ROWS - 1) ? '0 : rowOff + ROW_W'(1);
        end else if (chrTick) begin
          skipCnt <= skipCnt - CNT_W'(1);
        end
      end else if (scrollReq) begin
        scrollBusy <= 1'b1;
        skipCnt    <= CNT_W'(COLS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstN) assert_pos_range_R4: assert (int'(pos) < N);
  end

  assert_pos_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    chrTick |=> pos == ((int'($past(pos)) == N - 1) ? '0 : $past(pos) + POS_W'(1)));
  assert_valid_follows_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    !chrTick |=> !outValid);
  assert_skip_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chrTick && scrollBusy) |=> !outValid);
  assert_offset_moves_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    !lastSkip |=> $stable(rowOff));
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (scrollBusy && !lastSkip) |=> scrollBusy);
  assert_pend_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrPending && !strb.insert) |=> wrPending && $stable(pendPos));
  assert_pend_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.insert |=> !wrPending);
endmodule

// File: rtl/circ_screen_mem.sv
module circ_screen_mem
  import circ_screen_pkg::*;
#(
  parameter int ROWS    = 25,
  parameter int COLS    = 72,
  parameter int CHAR_W  = 6,
  parameter int SEG_LEN = 200,
  localparam int N     = ROWS * COLS,
  localparam int POS_W = $clog2(N),
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chrTick,
  input  logic              wrEn,
  input  logic [POS_W-1:0]  wrPos,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              scrollReq,
  output logic              outValid,
  output logic [CHAR_W-1:0] outChar,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic              wrPending,
  output logic              scrollBusy
);
  ringStrb_t strb;

  circ_screen_ctrl #(.ROWS(ROWS), .COLS(COLS)) uCtrl (
    .clk(clk), .rstN(rstN), .chrTick(chrTick), .wrEn(wrEn), .wrPos(wrPos),
    .scrollReq(scrollReq), .strb(strb), .outValid(outValid), .outRow(outRow),
    .outCol(outCol), .wrPending(wrPending), .scrollBusy(scrollBusy)
  );

  circ_screen_store #(.ROWS(ROWS), .COLS(COLS), .CHAR_W(CHAR_W), .SEG_LEN(SEG_LEN)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .outChar(outChar)
  );
endmodule

// File: tb/sim_circ_screen_mem.sv
module sim_circ_screen_mem;
  localparam int ROWS = 3, COLS = 4, CHAR_W = 6, SEG_LEN = 4;
  localparam int N = ROWS * COLS;
  localparam int POS_W = $clog2(N), ROW_W = $clog2(ROWS), COL_W = $clog2(COLS);

  logic clk = 0, rstN = 0, chrTick = 0, wrEn = 0, scrollReq = 0;
  logic [POS_W-1:0] wrPos = '0;
  logic [CHAR_W-1:0] wrData = '0;
  logic outValid, wrPending, scrollBusy;
  logic [CHAR_W-1:0] outChar;
  logic [ROW_W-1:0] outRow;
  logic [COL_W-1:0] outCol;

  circ_screen_mem #(.ROWS(ROWS), .COLS(COLS), .CHAR_W(CHAR_W), .SEG_LEN(SEG_LEN)) u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  int nChk = 0, nFail = 0;
  int mMem[N];
  int mPos = 0, mOff = 0, mPp = 0, mPd = 0, mCnt = 0;
  bit mPv = 0, mScr = 0, firstFrame = 1, justScr = 0, ignScr = 0;
  int firstCnt = 0;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive, predict, check
  task automatic step(bit tk, bit we, int wp, int wd, bit sr);
    bit oldPv, oldScr, landed, eValid, ignWr, scrEnd;
    int eChar, eRow, eCol, q;
    @(negedge clk);
    chrTick = tk; wrEn = we; wrPos = POS_W'(wp); wrData = CHAR_W'(wd); scrollReq = sr;
    oldPv = mPv; oldScr = mScr; landed = 0; eValid = 0; scrEnd = 0;
    eChar = 0; eRow = 0; eCol = 0;
    if (tk) begin
      landed = mPv && (mPp == mPos);
      eChar  = landed ? mPd : mMem[mPos];
      eValid = !oldScr;
      q = (mPos - mOff * COLS + N) % N;
      eRow = q / COLS; eCol = q % COLS;
      mMem[mPos] = eChar;
      mPos = (mPos + 1) % N;
      if (oldScr) begin
        if (mCnt == 1) scrEnd = 1; else mCnt--;
      end
    end
    mPv = oldPv && !landed;
    ignWr = we && (oldPv || wp >= N);
    if (we && !ignWr) begin mPv = 1; mPp = wp; mPd = wd; end
    if (scrEnd) begin mScr = 0; mOff = (mOff + 1) % ROWS; justScr = 1; end
    if (sr && !oldScr) begin mScr = 1; mCnt = COLS; ignScr = 0; end
    else if (sr) ignScr = 1;
    @(posedge clk); #5;
    chk((tk && oldScr) ? "R7 outValid during skip" : "R2 outValid", int'(outValid), int'(eValid));
    if (eValid) begin
      if (firstFrame) begin
        chk("R1 cleared char", int'(outChar), eChar);
        firstCnt++;
        if (firstCnt == N) firstFrame = 0;
      end else begin
        chk(landed ? "R5 written char" : "R3 recirculated char", int'(outChar), eChar);
      end
      chk(justScr ? "R9 row after scroll" : "R4 row", int'(outRow), eRow);
      chk(justScr ? "R9 col after scroll" : "R4 col", int'(outCol), eCol);
      justScr = 0;
    end
    chk(ignWr ? "R6 ignored write" : "R5 wrPending", int'(wrPending), int'(mPv));
    chk(ignScr ? "R8 ignored scroll" : "R7 scrollBusy", int'(scrollBusy), int'(mScr));
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) mMem[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 wrPending after reset", int'(wrPending), 0);
    chk("R1 scrollBusy after reset", int'(scrollBusy), 0);
    // first frame of zeros, with idle cycles mixed in
    for (int i = 0; i < N; i++) begin step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0); end
    // corner positions: last and first
    step(0, 1, N - 1, 6'h2a, 0);
    for (int i = 0; i < N + 1; i++) step(1, 0, 0, 0, 0);
    step(0, 1, 0, 6'h15, 0);
    step(1, 1, 3, 6'h3f, 0);          // R6: ignored, write pending
    for (int i = 0; i < 2 * N; i++) step(1, 0, 0, 0, 0);
    step(0, 1, N, 6'h11, 0);          // R6: out-of-range position
    step(0, 1, N + 3, 6'h12, 0);      // R6: out-of-range position
    for (int i = 0; i < N; i++) step(1, 0, 0, 0, 0);
    // scrolls past the wrap of the row offset, with redundant requests
    for (int s = 0; s < ROWS + 1; s++) begin
      step(1, 0, 0, 0, 1);
      step(1, 1, (s * 5) % N, 6'h20 + s, 1);   // R8 + R9 write during skip
      for (int i = 0; i < COLS + N; i++) step(1, 0, 0, 0, 0);
    end
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % (1 << POS_W),
           $urandom % (1 << CHAR_W), ($urandom % 40) == 0);
    end
    for (int i = 0; i < 2 * N + COLS; i++) step(1, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule